// File: doc/BRIEF.md
# Byte ALU with Condition-Code Register

This block is the arithmetic core of a small 8-bit datapath with two accumulators. It combines two 8-bit operands under a 4-bit operation select and produces an 8-bit result. A write-enable tells the surrounding datapath whether that result belongs in the destination. It also produces the next value of an 8-bit condition-code register, and it holds that register internally. Result, write-enable and next flags are combinational. The register loads the next-flags value on every rising clock edge.

The carry used by add-with-carry and by the rotates is the C bit of the held register. A flag-update enable picks whether the operation's flags are committed or the arithmetic flags are held. The interrupt-mask bit is carried in the register. Only two dedicated inputs change it: set and clear, and set wins when both are high. Instruction decode, memory and interrupt sequencing sit outside this block.

Top module: `cc_alu8`

## Requirements
- R1: A rising clock edge with `rst_n` low loads `ccr_q` with 0xD0, whatever the other inputs are. In that value the mask bit is 1 and C, V, Z, N and H are 0.
- R2: The flag layout is C bit 0, V bit 1, Z bit 2, N bit 3, mask bit 4, H bit 5. Bits 7 and 6 of both `ccr_next` and `ccr_q` always read 1. For every operation that updates flags, Z is (result == 0) and N is result bit 7.
- R3: Add (code 0) and add-with-carry (code 1) give result = (a + b + cin) mod 256, where cin is held C for code 1 and 0 for code 0. C is the carry out of bit 7 and H is the carry out of bit 3. V is set when both operands have the same sign and the result's sign differs.
- R4: Subtract (code 2) and compare (code 3) give result = (a - b) mod 256. C=1 exactly when b > a as unsigned values. V is set when the operand signs differ and the result's sign differs from a. H is unchanged. `wr_en` is 0 for compare and 1 for subtract.
- R5: AND (4), OR (5) and XOR (6) give the bitwise result. Bit test (7) gives a AND b with `wr_en` 0. All four clear V and leave C and H unchanged.
- R6: Complement (8) gives ~a, clears V and sets C.
- R7: Increment (9) and decrement (10) give a+1 and a-1 mod 256. V is set only for 0x7F and 0x80 respectively. C and H are unchanged.
- R8: Logical shift right (11) moves bit 0 into C and fills bit 7 with 0. Arithmetic shift left (12) moves bit 7 into C and fills bit 0 with 0. Arithmetic shift right (13) moves bit 0 into C and keeps bit 7. For these, V = N xor C after the shift and H is unchanged.
- R9: Rotate left (14) puts held C into bit 0 and bit 7 into C. Rotate right (15) puts held C into bit 7 and bit 0 into C. V = N xor C and H is unchanged.
- R10: With `upd_en` low, bits C, V, Z, N and H of `ccr_next` equal those of `ccr_q`, and the register keeps them across the edge. The result and `wr_en` are still produced.
- R11: The mask bit changes only through `imask_set` (to 1) and `imask_clr` (to 0), and set takes priority. At each edge out of reset, `ccr_q` takes the value `ccr_next` had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 8 | First operand (accumulator side; sole operand of unary ops) |
| op_b | input | 8 | Second operand |
| op_sel | input | 4 | Operation code, 0 to 15 as listed in R3 to R9 |
| upd_en | input | 1 | Commit the operation's flags |
| imask_set | input | 1 | Set the interrupt-mask bit |
| imask_clr | input | 1 | Clear the interrupt-mask bit |
| result | output | 8 | Operation result |
| wr_en | output | 1 | Result should be written to the destination |
| ccr_next | output | 8 | Value the flag register takes at the next edge |
| ccr_q | output | 8 | Current flag register |

## Verification
A wrong held carry shows up within one vector as a wrong add-with-carry sum or a wrong rotated bit on `result`. A flag committed when it should be held shows up on `ccr_next` at the very next operation and on `ccr_q` one edge later. The two-operand operations are swept over all 65,536 operand pairs. The unary operations are swept over all 256 values. In every case the current `ccr_q` is read as context and the expected result, write-enable and next flags are computed arithmetically. Directed clocked steps use literal values to check reset, mask priority and the register transfer.

// File: rtl/cc_alu8_pkg.sv
`timescale 1ns/1ps
// Shared operation codes and flag bit positions for the byte ALU.
package cc_alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_CMP = 4'd3,
        OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_BIT = 4'd7,
        OP_COM = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_LSR = 4'd11,
        OP_ASL = 4'd12, OP_ASR = 4'd13, OP_ROL = 4'd14, OP_ROR = 4'd15
    } alu_op_e;

    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;
    localparam int CC_I = 4;
    localparam int CC_H = 5;
    localparam logic [7:0] CC_RESET = 8'hD0;
endpackage

// File: rtl/cc_alu8_addsub.sv
`timescale 1ns/1ps
// Adder path: add, add-with-carry, subtract, compare, increment, decrement.
// Assumes W is even; subtraction is done as a + ~b + 1, so carry is inverted into a borrow.
module cc_alu8_addsub
    import cc_alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         v_out,
    output logic         h_out
);
    localparam int HW = W / 2;

    logic [W-1:0] b_eff;
    logic         c_in0;
    logic         is_sub;
    logic [W:0]   full_sum;
    logic [HW:0]  half_sum;

    // Pick the second addend and the injected carry for each operation.
    always_comb begin
        is_sub = 1'b0;
        b_eff  = b;
        c_in0  = 1'b0;
        unique case (op)
            OP_ADC:         c_in0 = cin;
            OP_SUB, OP_CMP: begin b_eff = ~b; c_in0 = 1'b1; is_sub = 1'b1; end
            OP_INC:         b_eff = W'(1);
            OP_DEC:         b_eff = {W{1'b1}};
            default:        ;
        endcase
    end

    assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_in0};
    assign half_sum = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_in0};

    // Derive result and arithmetic flags from the sums.
    always_comb begin
        res   = full_sum[W-1:0];
        c_out = is_sub ? ~full_sum[W] : full_sum[W];
        h_out = half_sum[HW];
        v_out = (a[W-1] == b_eff[W-1]) && (full_sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/cc_alu8_bitops.sv
`timescale 1ns/1ps
// Logic, complement, shift and rotate path. Unary operations use a only.
// Assumes W >= 2; c_out is only meaningful for complement, shifts and rotates.
module cc_alu8_bitops
    import cc_alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out
);
    // Bitwise and single-position move results with the bit shifted out.
    always_comb begin
        res   = a;
        c_out = cin;
        unique case (op)
            OP_AND, OP_BIT: res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_COM:         begin res = ~a;                      c_out = 1'b1;     end
            OP_LSR:         begin res = {1'b0, a[W-1:1]};        c_out = a[0];     end
            OP_ASL:         begin res = {a[W-2:0], 1'b0};        c_out = a[W-1];   end
            OP_ASR:         begin res = {a[W-1], a[W-1:1]};      c_out = a[0];     end
            OP_ROL:         begin res = {a[W-2:0], cin};         c_out = a[W-1];   end
            OP_ROR:         begin res = {cin, a[W-1:1]};         c_out = a[0];     end
            default:        ;
        endcase
    end
endmodule

// File: rtl/cc_alu8_ccreg.sv
`timescale 1ns/1ps
// Condition-code register: commits candidate flags when enabled, handles the mask bit.
// Assumes cand carries the operation's full flag set; bits 7:6 are forced to 1.
module cc_alu8_ccreg
    import cc_alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_en,
    input  logic       imask_set,
    input  logic       imask_clr,
    input  logic [7:0] cand,
    output logic [7:0] ccr_d,
    output logic [7:0] ccr_q
);
    logic mask_d;

    // Mask bit: set has priority over clear, otherwise hold.
    always_comb begin
        if (imask_set)      mask_d = 1'b1;
        else if (imask_clr) mask_d = 1'b0;
        else                mask_d = ccr_q[CC_I];
    end

    // Assemble the next register value.
    always_comb begin
        ccr_d        = upd_en ? cand : ccr_q;
        ccr_d[7:6]   = 2'b11;
        ccr_d[CC_I]  = mask_d;
    end

    // Flag storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ccr_q <= CC_RESET;
        else        ccr_q <= ccr_d;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !imask_set && !imask_clr) |=> (ccr_q == $past(ccr_q))); // R10
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        imask_set |=> ccr_q[CC_I]); // R11
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_clr && !imask_set) |=> !ccr_q[CC_I]); // R11
endmodule

// File: rtl/cc_alu8.sv
`timescale 1ns/1ps
// Byte ALU top: selects between adder and bit-operation paths, applies each
// operation's flag rules, and keeps the condition-code register.
// Assumes the carry for add-with-carry and rotates is the held C bit.
module cc_alu8
    import cc_alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] op_a,
    input  logic [7:0] op_b,
    input  logic [3:0] op_sel,
    input  logic       upd_en,
    input  logic       imask_set,
    input  logic       imask_clr,
    output logic [7:0] result,
    output logic       wr_en,
    output logic [7:0] ccr_next,
    output logic [7:0] ccr_q
);
    localparam int W = 8;

    alu_op_e      op;
    logic [W-1:0] as_res, bo_res;
    logic         as_c, as_v, as_h, bo_c;
    logic         use_adder;
    logic         f_c, f_v, f_h, f_n, f_z;
    logic [7:0]   cand;

    assign op = alu_op_e'(op_sel);

    cc_alu8_addsub #(.W(W)) u_addsub (
        .a(op_a), .b(op_b), .op(op), .cin(ccr_q[CC_C]),
        .res(as_res), .c_out(as_c), .v_out(as_v), .h_out(as_h)
    );

    cc_alu8_bitops #(.W(W)) u_bitops (
        .a(op_a), .b(op_b), .op(op), .cin(ccr_q[CC_C]),
        .res(bo_res), .c_out(bo_c)
    );

    // Choose the datapath that owns the operation.
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_INC, OP_DEC: use_adder = 1'b1;
            default:                                          use_adder = 1'b0;
        endcase
    end

    assign result = use_adder ? as_res : bo_res;
    assign wr_en  = !(op == OP_CMP || op == OP_BIT);
    assign f_z    = (result == '0);
    assign f_n    = result[W-1];

    // Per-operation flag rules; untouched flags copy the held value.
    always_comb begin
        f_c = ccr_q[CC_C];
        f_v = ccr_q[CC_V];
        f_h = ccr_q[CC_H];
        unique case (op)
            OP_ADD, OP_ADC:                 begin f_c = as_c; f_v = as_v; f_h = as_h; end
            OP_SUB, OP_CMP:                 begin f_c = as_c; f_v = as_v; end
            OP_INC, OP_DEC:                 f_v = as_v;
            OP_AND, OP_OR, OP_XOR, OP_BIT:  f_v = 1'b0;
            OP_COM:                         begin f_c = bo_c; f_v = 1'b0; end
            default:                        begin f_c = bo_c; f_v = f_n ^ bo_c; end
        endcase
    end

    assign cand = {2'b11, f_h, ccr_q[CC_I], f_n, f_z, f_v, f_c};

    cc_alu8_ccreg u_ccreg (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en),
        .imask_set(imask_set), .imask_clr(imask_clr),
        .cand(cand), .ccr_d(ccr_next), .ccr_q(ccr_q)
    );

    AST_CMP_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> ((as_res == 8'h00) == (op_a == op_b))); // R4
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op == OP_INC || op == OP_DEC)) |=> (ccr_q[CC_C] == $past(ccr_q[CC_C]))); // R7
    AST_LOGIC_CLEAR_V: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_BIT)) |=> !ccr_q[CC_V]); // R5
    AST_COM_SET_C: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op == OP_COM) |=> ccr_q[CC_C]); // R6
endmodule

// File: tb/cc_alu8_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed clocked steps plus exhaustive operand sweeps.
module cc_alu8_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = 8'h00, op_b = 8'h00;
    logic [3:0] op_sel = 4'd0;
    logic       upd_en = 1'b0, imask_set = 1'b0, imask_clr = 1'b0;
    logic [7:0] result, ccr_next, ccr_q;
    logic       wr_en;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    cc_alu8 uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .upd_en(upd_en), .imask_set(imask_set), .imask_clr(imask_clr),
        .result(result), .wr_en(wr_en), .ccr_next(ccr_next), .ccr_q(ccr_q)
    );

    always #10 clk = ~clk;

    // Expected {wr_en, result, next flags} from the requirements, given held flags f.
    function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
        logic [7:0] r;
        logic [8:0] s;
        logic [4:0] hs;
        logic c, v, h, wr, ci;
        c = f[0]; v = f[1]; h = f[5]; wr = 1'b1; r = a;
        ci = (op == 4'd1) ? f[0] : 1'b0;
        case (op)
            4'd0, 4'd1: begin
                s  = {1'b0, a} + {1'b0, b} + {8'd0, ci};
                hs = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, ci};
                r = s[7:0]; c = s[8]; h = hs[4];
                v = (a[7] == b[7]) && (r[7] != a[7]);
            end
            4'd2, 4'd3: begin
                r = a - b; c = (b > a);
                v = (a[7] != b[7]) && (r[7] != a[7]);
                wr = (op != 4'd3);
            end
            4'd4: begin r = a & b; v = 1'b0; end
            4'd5: begin r = a | b; v = 1'b0; end
            4'd6: begin r = a ^ b; v = 1'b0; end
            4'd7: begin r = a & b; v = 1'b0; wr = 1'b0; end
            4'd8: begin r = ~a; v = 1'b0; c = 1'b1; end
            4'd9: begin r = a + 8'd1; v = (a == 8'h7F); end
            4'd10: begin r = a - 8'd1; v = (a == 8'h80); end
            4'd11: begin r = a >> 1; c = a[0]; v = r[7] ^ c; end
            4'd12: begin r = a << 1; c = a[7]; v = r[7] ^ c; end
            4'd13: begin r = {a[7], a[7:1]}; c = a[0]; v = r[7] ^ c; end
            4'd14: begin r = {a[6:0], f[0]}; c = a[7]; v = r[7] ^ c; end
            default: begin r = {f[0], a[7:1]}; c = a[0]; v = r[7] ^ c; end
        endcase
        return {wr, r, 2'b11, h, f[4], r[7], (r == 8'h00), v, c};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:         return "R3";
            4'd2, 4'd3:         return "R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R5";
            4'd8:               return "R6";
            4'd9, 4'd10:        return "R7";
            4'd11, 4'd12, 4'd13: return "R8";
            default:            return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clocked operation: check combinational outputs, then the register after the edge.
    task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic upd, input logic set, input logic clr,
                        input logic [7:0] exp_res, input logic exp_wr,
                        input logic [7:0] exp_q, input string tag);
        @(negedge clk);
        op_sel = op; op_a = a; op_b = b; upd_en = upd; imask_set = set; imask_clr = clr;
        #5;
        chk(tag, {8'h00, exp_wr, exp_res}, {8'h00, wr_en, result});
        @(posedge clk); #5;
        chk(tag, {9'h000, ccr_q}, {9'h000, exp_q});
    endtask

    // Apply every operand pair (or every a when b_span is 1) without a clock dependency.
    task automatic sweep(input logic [3:0] op, input int b_span, input logic upd);
        logic [16:0] e;
        logic [7:0]  held;
        @(negedge clk); #0.25;
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < b_span; ib++) begin
                op_sel = op; op_a = 8'(ia); op_b = 8'(ib); upd_en = upd;
                imask_set = 1'b0; imask_clr = 1'b0;
                #0.5;
                held = ccr_q;
                e = model(op, 8'(ia), 8'(ib), held);
                if (upd) chk(tag_of(op), {wr_en, result, ccr_next}, e);
                else     chk("R10", {wr_en, result, ccr_next}, {e[16:8], held});
                #0.5;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R11: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset value
        upd_en = 1'b1; op_sel = 4'd8;
        repeat (2) @(posedge clk);
        #5 chk("R1", {9'h000, ccr_q}, {9'h000, 8'hD0});
        @(negedge clk); rst_n = 1'b1;

        // Directed clocked steps with literal expectations
        step(4'd0,  8'h4F, 8'h40, 1, 0, 0, 8'h8F, 1, 8'hDA, "R3");
        step(4'd0,  8'hB1, 8'hC0, 1, 0, 0, 8'h71, 1, 8'hD3, "R3");
        step(4'd1,  8'h3A, 8'h7C, 1, 0, 0, 8'hB7, 1, 8'hFA, "R3");
        step(4'd8,  8'h00, 8'h00, 1, 0, 0, 8'hFF, 1, 8'hF9, "R6");
        step(4'd14, 8'h7A, 8'h00, 1, 0, 0, 8'hF5, 1, 8'hFA, "R9");
        step(4'd11, 8'h7A, 8'h00, 1, 0, 0, 8'h3D, 1, 8'hF0, "R8");
        step(4'd12, 8'h7A, 8'h00, 1, 0, 0, 8'hF4, 1, 8'hFA, "R8");
        step(4'd3,  8'h37, 8'h37, 1, 0, 0, 8'h00, 0, 8'hF4, "R4");
        step(4'd3,  8'h10, 8'h20, 1, 0, 0, 8'hF0, 0, 8'hF9, "R4");
        step(4'd0,  8'h00, 8'h00, 0, 0, 1, 8'h00, 1, 8'hE9, "R11");
        step(4'd0,  8'hFF, 8'h01, 0, 0, 0, 8'h00, 1, 8'hE9, "R10");
        step(4'd0,  8'hFF, 8'h01, 0, 1, 1, 8'h00, 1, 8'hF9, "R11");
        step(4'd9,  8'h7F, 8'h00, 1, 0, 0, 8'h80, 1, 8'hFB, "R7");
        step(4'd10, 8'h00, 8'h00, 1, 0, 0, 8'hFF, 1, 8'hF9, "R7");
        step(4'd6,  8'h55, 8'h55, 1, 0, 0, 8'h00, 1, 8'hF5, "R5");
        step(4'd7,  8'hF0, 8'h0F, 1, 0, 0, 8'h00, 0, 8'hF5, "R5");
        step(4'd13, 8'h81, 8'h00, 1, 0, 0, 8'hC0, 1, 8'hF9, "R8");
        step(4'd15, 8'h02, 8'h00, 1, 0, 0, 8'h81, 1, 8'hFA, "R9");
        #1 chk("R2", {15'h0000, ccr_q[7:6]}, {15'h0000, 2'b11});

        // R1: reset during an active update still loads the reset value
        @(negedge clk); rst_n = 1'b0; op_sel = 4'd0; op_a = 8'hFF; op_b = 8'h01; upd_en = 1'b1;
        @(posedge clk); #5 chk("R1", {9'h000, ccr_q}, {9'h000, 8'hD0});
        @(negedge clk); rst_n = 1'b1;

        // Exhaustive sweeps, flags committed
        for (int op = 0; op < 8; op++)  sweep(4'(op), 256, 1'b1);
        for (int op = 8; op < 16; op++) sweep(4'(op), 1, 1'b1);
        // R10: flags held for every operation
        for (int op = 0; op < 16; op++) sweep(4'(op), 4, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule